// File: doc/BRIEF.md
# Exception Priority Sequencer

This block chooses which exception a small processor core takes and the cycle in which it takes it. It watches a reset line, a watchdog overflow strobe, the NMI level, the trace flag, the pending interrupt lines, a trap-instruction strobe and the 2-bit interrupt control mode. It also watches a strobe marking each instruction or handler boundary, which carries a 2-bit code for the class of what just finished. Each cycle it issues at most one registered one-hot grant, together with a vector code. When a reset starts, it also records whether that reset is power-on or manual.

Four classes compete under a fixed order: reset, then trace, then interrupt, then trap. Trace and interrupt are only ever taken at a boundary. A trap can be taken in any cycle outside reset. A request that loses stays pending and is granted later. All pins are plain control and status signals. There is no data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `exc_priority_seq`

## Requirements
- R1: `gnt` is zero or one-hot, with bit 0 = reset, bit 1 = trace, bit 2 = interrupt and bit 3 = trap. Each accepted exception holds its bit high for exactly one cycle. `vec` is meaningful only while `gnt` is non-zero.
- R2: A reset starts on the cycle where `res_pin` is sampled high after having been sampled low, or on a cycle where `wdt_ovf` is high while `res_pin` is high. `gnt` = 0001 and `vec` = 0 appear on the next cycle.
- R3: When a reset starts, `rst_manual` takes the inverse of `nmi` at that moment: NMI high gives power-on (0) and NMI low gives manual (1). It holds that value until the next reset start.
- R4: While `res_pin` is low, no grant is issued and any trap strobe is discarded. A trap still pending when a reset starts is also discarded.
- R5: A trace grant (`vec` = 5) needs three things: `bnd_stb` high, `trace_en` high and `intm` = 2. It is never granted when `bnd_cls` = 1 (return from exception).
- R6: An interrupt grant (`vec` = 7) needs `bnd_stb` high and any bit of `irq_req` set. It is blocked when `bnd_cls` = 2 (control-register logic/load instruction). It is also blocked at the first boundary after a reset grant.
- R7: A trap strobe is accepted in any cycle outside reset, with or without a boundary. Its grant carries `vec` = 8 + `trap_num`.
- R8: When several requests are live in one cycle, the highest in the order reset > trace > interrupt > trap is granted. A losing trap stays pending and is granted in the next cycle with no competitor. A losing interrupt stays requested while its line is held, and is granted at a later boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous flop reset, active low |
| res_pin | input | 1 | CPU reset line; low holds reset, rising edge starts it |
| wdt_ovf | input | 1 | Watchdog overflow strobe |
| nmi | input | 1 | NMI level, selects reset type |
| intm | input | 2 | Interrupt control mode |
| trace_en | input | 1 | Trace flag |
| irq_req | input | IRQ_W | Pending interrupt lines, level |
| trap_stb | input | 1 | Trap instruction executed |
| trap_num | input | TRAP_W | Trap number |
| bnd_stb | input | 1 | Instruction or handler boundary |
| bnd_cls | input | 2 | 0 plain, 1 return, 2 control-reg modify, 3 handler end |
| gnt | output | 4 | One-hot exception grant |
| vec | output | VEC_W | Vector code |
| rst_manual | output | 1 | 1 = last reset was manual |

## Verification
The bench builds the block with IRQ_W = 4 and TRAP_W = 2. This keeps the input space small enough to sweep every combination of the four control modes, the trace flag, the four boundary classes, the boundary strobe, an interrupt and a trap. For each combination it checks the grant and vector in that cycle, and the trap that drains in the cycle after. Directed sequences cover the reset edge, the watchdog, the NMI-selected reset type, the interrupt block after reset, and trace taking precedence over a held interrupt.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int NUM_EXC = 4;
  localparam int G_RST = 0;
  localparam int G_TRC = 1;
  localparam int G_IRQ = 2;
  localparam int G_TRP = 3;

  typedef enum logic [1:0] {
    BC_PLAIN  = 2'd0,
    BC_RTE    = 2'd1,
    BC_CTLMOD = 2'd2,
    BC_EXCEND = 2'd3
  } bnd_cls_e;

  localparam logic [1:0] MODE_TRACE = 2'd2;

  localparam int VEC_RST      = 0;
  localparam int VEC_TRC      = 5;
  localparam int VEC_IRQ      = 7;
  localparam int VEC_TRP_BASE = 8;
endpackage

// File: rtl/exc_reset_ctl.sv
module exc_reset_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic res_pin,
  input  logic wdt_ovf,
  input  logic nmi,
  output logic rst_start,
  output logic rst_hold,
  output logic rst_manual
);
  logic pin_q;
  logic manual_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= 1'b1;
    else        pin_q <= res_pin;
  end

  assign rst_hold  = !res_pin;
  assign rst_start = res_pin && (!pin_q || wdt_ovf);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         manual_q <= 1'b0;
    else if (rst_start) manual_q <= !nmi;
  end

  assign rst_manual = manual_q;
endmodule

// File: rtl/exc_trap_hold.sv
module exc_trap_hold #(
  parameter int TRAP_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              stb,
  input  logic [TRAP_W-1:0] num,
  input  logic              taken,
  output logic              req,
  output logic [TRAP_W-1:0] num_o
);
  logic              pend_q;
  logic [TRAP_W-1:0] num_q;

  assign req   = pend_q || stb;
  assign num_o = pend_q ? num_q : num;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      num_q  <= '0;
    end else if (flush || taken) begin
      pend_q <= 1'b0;
    end else if (stb && !pend_q) begin
      pend_q <= 1'b1;
      num_q  <= num;
    end
  end
endmodule

// File: rtl/exc_pick.sv
module exc_pick #(
  parameter int N = 4
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    if (i == 0) begin : g_top
      assign gnt[i] = req[i];
    end else begin : g_low
      assign gnt[i] = req[i] && !(|req[i-1:0]);
    end
  end
endmodule

// File: rtl/exc_priority_seq.sv
module exc_priority_seq
  import exc_pkg::*;
#(
  parameter int IRQ_W  = 8,
  parameter int TRAP_W = 2,
  localparam int VEC_W = $clog2(VEC_TRP_BASE + (1 << TRAP_W))
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               res_pin,
  input  logic               wdt_ovf,
  input  logic               nmi,
  input  logic [1:0]         intm,
  input  logic               trace_en,
  input  logic [IRQ_W-1:0]   irq_req,
  input  logic               trap_stb,
  input  logic [TRAP_W-1:0]  trap_num,
  input  logic               bnd_stb,
  input  logic [1:0]         bnd_cls,
  output logic [NUM_EXC-1:0] gnt,
  output logic [VEC_W-1:0]   vec,
  output logic               rst_manual
);
  bnd_cls_e          cls;
  logic              rst_start, rst_hold;
  logic              trap_req;
  logic [TRAP_W-1:0] trap_sel;
  logic              trc_ok, irq_ok;
  logic              after_rst_q;
  logic [NUM_EXC-1:0] live, gnt_nx, gnt_q;
  logic [VEC_W-1:0]  vec_nx, vec_q;

  assign cls = bnd_cls_e'(bnd_cls);

  exc_reset_ctl u_rst (
    .clk(clk), .rst_n(rst_n), .res_pin(res_pin), .wdt_ovf(wdt_ovf), .nmi(nmi),
    .rst_start(rst_start), .rst_hold(rst_hold), .rst_manual(rst_manual)
  );

  exc_trap_hold #(.TRAP_W(TRAP_W)) u_trap (
    .clk(clk), .rst_n(rst_n), .flush(rst_hold || rst_start),
    .stb(trap_stb && !rst_hold), .num(trap_num), .taken(gnt_nx[G_TRP]),
    .req(trap_req), .num_o(trap_sel)
  );

  assign trc_ok = bnd_stb && trace_en && (intm == MODE_TRACE) && (cls != BC_RTE);
  assign irq_ok = bnd_stb && (|irq_req) && (cls != BC_CTLMOD) && !after_rst_q;

  always_comb begin
    live        = '0;
    live[G_RST] = rst_start;
    live[G_TRC] = trc_ok;
    live[G_IRQ] = irq_ok;
    live[G_TRP] = trap_req;
    if (rst_hold) live = '0;
  end

  exc_pick #(.N(NUM_EXC)) u_pick (.req(live), .gnt(gnt_nx));

  always_comb begin
    vec_nx = '0;
    if (gnt_nx[G_RST])      vec_nx = VEC_W'(VEC_RST);
    else if (gnt_nx[G_TRC]) vec_nx = VEC_W'(VEC_TRC);
    else if (gnt_nx[G_IRQ]) vec_nx = VEC_W'(VEC_IRQ);
    else if (gnt_nx[G_TRP]) vec_nx = VEC_W'(VEC_TRP_BASE) + VEC_W'(trap_sel);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              after_rst_q <= 1'b0;
    else if (gnt_nx[G_RST])  after_rst_q <= 1'b1;
    else if (bnd_stb)        after_rst_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt_q <= '0;
      vec_q <= '0;
    end else begin
      gnt_q <= gnt_nx;
      vec_q <= vec_nx;
    end
  end

  assign gnt = gnt_q;
  assign vec = vec_q;
endmodule

// File: rtl/exc_seq_chk.sv
module exc_seq_chk #(
  parameter int VEC_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             res_pin,
  input logic             wdt_ovf,
  input logic             nmi,
  input logic [1:0]       intm,
  input logic             bnd_stb,
  input logic [1:0]       bnd_cls,
  input logic [3:0]       gnt,
  input logic [VEC_W-1:0] vec,
  input logic             rst_manual
);
  // R1
  onehot_grant_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(gnt));
  // R2
  wdt_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wdt_ovf && res_pin) |=> (gnt == 4'b0001 && vec == '0));
  // R3
  reset_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gnt[0] |-> (rst_manual == !$past(nmi)));
  // R4
  hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !res_pin |=> (gnt == 4'b0000));
  // R5
  trace_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gnt[1] |-> ($past(intm) == 2'd2 && $past(bnd_stb) && $past(bnd_cls) != 2'd1));
  // R6
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gnt[2] |-> ($past(bnd_stb) && $past(bnd_cls) != 2'd2 && !$past(gnt[0])));
  // R7
  trap_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gnt[3] |-> (vec >= VEC_W'(8)));
endmodule

bind exc_priority_seq exc_seq_chk #(.VEC_W(VEC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .res_pin(res_pin), .wdt_ovf(wdt_ovf), .nmi(nmi),
  .intm(intm), .bnd_stb(bnd_stb), .bnd_cls(bnd_cls), .gnt(gnt), .vec(vec),
  .rst_manual(rst_manual)
);

// File: tb/sim_exc_priority_seq.sv
module sim_exc_priority_seq;
  localparam int IRQ_W  = 4;
  localparam int TRAP_W = 2;
  localparam int VEC_W  = 4;

  logic clk = 1'b0;
  logic rst_n, res_pin, wdt_ovf, nmi, trace_en, trap_stb, bnd_stb;
  logic [1:0] intm, bnd_cls;
  logic [IRQ_W-1:0] irq_req;
  logic [TRAP_W-1:0] trap_num;
  logic [3:0] gnt;
  logic [VEC_W-1:0] vec;
  logic rst_manual;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  exc_priority_seq #(.IRQ_W(IRQ_W), .TRAP_W(TRAP_W)) u0 (
    .clk(clk), .rst_n(rst_n), .res_pin(res_pin), .wdt_ovf(wdt_ovf), .nmi(nmi),
    .intm(intm), .trace_en(trace_en), .irq_req(irq_req), .trap_stb(trap_stb),
    .trap_num(trap_num), .bnd_stb(bnd_stb), .bnd_cls(bnd_cls),
    .gnt(gnt), .vec(vec), .rst_manual(rst_manual)
  );

  task automatic chk(input string req, input logic [3:0] g_exp, input int v_exp);
    checks++;
    if (gnt !== g_exp || (g_exp != 4'b0 && vec !== VEC_W'(v_exp))) begin
      errors++;
      $display("FAIL %s gnt=%b vec=%0d expected gnt=%b vec=%0d", req, gnt, vec, g_exp, v_exp);
    end
  endtask

  task automatic chk_type(input string req, input logic m_exp);
    checks++;
    if (rst_manual !== m_exp) begin
      errors++;
      $display("FAIL %s rst_manual=%b expected %b", req, rst_manual, m_exp);
    end
  endtask

  task automatic quiet();
    wdt_ovf = 0; trap_stb = 0; bnd_stb = 0; bnd_cls = 2'd0;
    irq_req = '0; trace_en = 0;
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0; res_pin = 0; nmi = 1; intm = 2'd0; trap_num = '0;
    quiet();
    repeat (3) tick();
    rst_n = 1;
    tick();
    chk("R4 reset state", 4'b0000, 0);
    chk_type("R3 reset state", 1'b0);

    // R4: trap while reset held is discarded
    trap_stb = 1; trap_num = 2'd3;
    tick();
    chk("R4 trap during hold", 4'b0000, 0);
    trap_stb = 0;
    // R2 + R3: rising edge with NMI high gives power-on reset
    res_pin = 1; nmi = 1;
    tick();
    chk("R2 pin rise grant", 4'b0001, 0);
    chk_type("R3 power-on", 1'b0);
    tick();
    chk("R1 R4 single cycle, trap discarded", 4'b0000, 0);

    // R6: first boundary after reset blocks interrupts
    bnd_stb = 1; bnd_cls = 2'd3; irq_req = 4'b0100;
    tick();
    chk("R6 blocked after reset", 4'b0000, 0);
    tick();
    chk("R6 irq at next boundary", 4'b0100, 7);
    quiet();

    // R2 + R3: watchdog with NMI low gives manual reset
    wdt_ovf = 1; nmi = 0;
    tick();
    chk("R2 watchdog grant", 4'b0001, 0);
    chk_type("R3 manual", 1'b1);
    wdt_ovf = 0; nmi = 1; bnd_stb = 1;
    tick();
    chk("R1 grant cleared", 4'b0000, 0);
    chk_type("R3 type held", 1'b1);
    quiet();

    // R8: trace beats a held interrupt, which follows at the next boundary
    intm = 2'd2; trace_en = 1; irq_req = 4'b0001; bnd_stb = 1; bnd_cls = 2'd0;
    tick();
    chk("R8 trace first", 4'b0010, 5);
    trace_en = 0; bnd_cls = 2'd3;
    tick();
    chk("R8 irq second", 4'b0100, 7);
    quiet();

    // R8 + R4: reset beats a trap in the same cycle, trap is dropped
    wdt_ovf = 1; trap_stb = 1; trap_num = 2'd1;
    tick();
    chk("R8 reset over trap", 4'b0001, 0);
    quiet();
    tick();
    chk("R4 trap flushed by reset", 4'b0000, 0);
    bnd_stb = 1;
    tick();
    quiet();
    tick();

    // R5 R6 R7 R8 sweep
    for (int c = 0; c < 256; c++) begin
      logic [1:0] m, k;
      logic tr, ir, tp, bs;
      logic [3:0] ge, gb;
      int ve;
      m = c[1:0]; tr = c[2]; k = c[4:3]; ir = c[5]; tp = c[6]; bs = c[7];
      intm = m; trace_en = tr; bnd_cls = k; irq_req = ir ? 4'b1000 : 4'b0;
      trap_stb = tp; trap_num = c[1:0] ^ c[4:3]; bnd_stb = bs;
      ge = 4'b0; ve = 0;
      if (bs && tr && m == 2'd2 && k != 2'd1) begin ge = 4'b0010; ve = 5; end
      else if (bs && ir && k != 2'd2) begin ge = 4'b0100; ve = 7; end
      else if (tp) begin ge = 4'b1000; ve = 8 + int'(trap_num); end
      tick();
      if (ge == 4'b0010) chk("R5 sweep trace", ge, ve);
      else if (ge == 4'b0100) chk("R6 sweep irq", ge, ve);
      else chk("R7 sweep trap or none", ge, ve);
      gb = (tp && ge != 4'b1000) ? 4'b1000 : 4'b0000;
      quiet();
      tick();
      chk("R8 sweep pending trap", gb, 8 + int'(c[1:0] ^ c[4:3]));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule